// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block decides, for every instruction handed to it, whether it may go ahead or must raise a fault. The decision uses the current privilege level (0 to 3), the execution mode (real, protected or virtual-8086) and a small set of control and flag bits. It covers four concerns: reading the time-stamp counter, reading a performance counter, moving to or from debug registers, and checking data alignment on memory accesses.

An execution pipeline presents one request per cycle with `in_valid`. Exactly one cycle later the block returns a registered verdict with `out_valid`: allow, general-protection fault, undefined-opcode fault, or alignment-check fault. For debug-register moves it also returns the register index to use. When the older aliasing behaviour is in force, that index is remapped.

Top module: `priv_gate`

## Requirements
- R1: While reset is held and after it is released with no request, `out_valid` is 0, `out_verdict` is 0 (allow) and `out_dbg_idx` is 0.
- R2: `out_valid` equals `in_valid` of the previous cycle, and the verdict and index for a request appear in that same cycle. Verdict codes: 0 allow, 1 general-protection, 2 undefined-opcode, 3 alignment-check.
- R3: A time-stamp read (class code 1) gets a general-protection verdict when `cr4_tsd` is 1 and the privilege level is not 0. With `cr4_tsd` at 0 it is allowed at every level.
- R4: A performance-counter read (class code 2) is allowed at every level when `cr4_pce` is 1. With `cr4_pce` at 0 it gets a general-protection verdict at any level other than 0.
- R5: A debug-register move (class code 3) that names index 4 or 5 gets an undefined-opcode verdict when `cr4_de` is 1.
- R6: With `cr4_de` at 0, a debug-register move naming index 4 returns index 6 and one naming index 5 returns index 7. In both cases the verdict is allow. All other indices, and all requests of other classes, return `in_dbg_idx` unchanged.
- R7: An alignment-check verdict is given only when all of these hold: `in_mem` is 1, `cr0_am` is 1, `eflags_ac` is 1, the privilege level is 3, the mode is protected (code 1) or virtual-8086 (code 2), and the access is misaligned.
- R8: An access is misaligned when the low address bits are not a multiple of its size. Size codes are 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 8. A 1-byte access is never misaligned.
- R9: In real mode (code 0), and for mode code 3, no alignment-check verdict is ever given.
- R10: When a request qualifies for both a privilege fault (general-protection or undefined-opcode) and an alignment fault, the privilege fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_class | input | 2 | 0 plain memory op, 1 time-stamp read, 2 counter read, 3 debug-register move |
| in_cpl | input | 2 | Current privilege level |
| in_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 treated as real |
| cr0_am | input | 1 | Alignment-mask control bit |
| cr4_tsd | input | 1 | Restrict time-stamp reads to level 0 |
| cr4_de | input | 1 | Debug-register extension control |
| cr4_pce | input | 1 | Permit counter reads at any level |
| eflags_ac | input | 1 | Alignment-check flag |
| in_mem | input | 1 | Request carries a data access |
| in_size | input | 2 | Access size code |
| in_addr_lo | input | 3 | Low bits of the data address |
| in_dbg_idx | input | 3 | Debug register index named by the request |
| out_valid | output | 1 | Verdict valid |
| out_verdict | output | 2 | Verdict code |
| out_dbg_idx | output | 3 | Debug register index to use |

## Verification
The bench goes after the boundary between privilege levels 0 and 3 for each counter-read control. A design with a flipped polarity would fault level-0 reads, or let level-3 reads through. Debug indices 3, 4, 5 and 6 are driven with both settings of the extension bit, which exposes a swapped alias (4 mapped to 7) or a remap that leaks to indices outside 4 and 5. Every size code is driven at every low-address value, and each alignment enable is dropped one at a time. This includes real mode, where a missing mode term would raise spurious alignment faults. Requests that qualify for both a privilege fault and an alignment fault show whether the priority order is inverted.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;

    typedef enum logic [1:0] {
        CLS_MEM = 2'd0,
        CLS_TSC = 2'd1,
        CLS_PMC = 2'd2,
        CLS_DBG = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        V_ALLOW = 2'd0,
        V_GP    = 2'd1,
        V_UD    = 2'd2,
        V_AC    = 2'd3
    } verdict_e;

endpackage

// File: rtl/priv_gate_rules.sv
module priv_gate_rules
    import priv_gate_pkg::*;
#(
    parameter int CPL_W     = 2,
    parameter int DBG_IDX_W = 3,
    parameter int ALIAS_LO  = 4
) (
    input  logic [1:0]           cls,
    input  logic [CPL_W-1:0]     cpl,
    input  logic                 tsd,
    input  logic                 pce,
    input  logic                 de,
    input  logic [DBG_IDX_W-1:0] dbg_idx,
    output logic                 fault,
    output logic [1:0]           fault_code
);
    localparam logic [DBG_IDX_W-1:0] IDX_A = DBG_IDX_W'(ALIAS_LO);
    localparam logic [DBG_IDX_W-1:0] IDX_B = DBG_IDX_W'(ALIAS_LO + 1);

    logic kernel;
    logic alias_hit;

    always_comb begin
        kernel     = (cpl == '0);
        alias_hit  = (dbg_idx == IDX_A) || (dbg_idx == IDX_B);
        fault      = 1'b0;
        fault_code = V_ALLOW;
        unique case (cls_e'(cls))
            CLS_TSC: begin
                if (tsd && !kernel) begin
                    fault      = 1'b1;
                    fault_code = V_GP;
                end
            end
            CLS_PMC: begin
                if (!pce && !kernel) begin
                    fault      = 1'b1;
                    fault_code = V_GP;
                end
            end
            CLS_DBG: begin
                if (de && alias_hit) begin
                    fault      = 1'b1;
                    fault_code = V_UD;
                end
            end
            default: begin
                fault      = 1'b0;
                fault_code = V_ALLOW;
            end
        endcase
    end
endmodule

// File: rtl/priv_gate_align.sv
module priv_gate_align
    import priv_gate_pkg::*;
#(
    parameter int CPL_W     = 2,
    parameter int SIZE_W    = 2,
    parameter int ADDR_LO_W = 3
) (
    input  logic                 mem,
    input  logic                 am,
    input  logic                 ac,
    input  logic [CPL_W-1:0]     cpl,
    input  logic [1:0]           mode,
    input  logic [SIZE_W-1:0]    size,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    output logic                 align_fault
);
    localparam logic [CPL_W-1:0] USER_CPL = '1;

    logic [ADDR_LO_W-1:0] low_mask;
    logic                 misaligned;
    logic                 mode_ok;

    for (genvar i = 0; i < ADDR_LO_W; i++) begin : g_mask
        assign low_mask[i] = (32'(size) > i);
    end

    always_comb begin
        misaligned  = |(addr_lo & low_mask);
        mode_ok     = (mode_e'(mode) == MODE_PROT) || (mode_e'(mode) == MODE_V86);
        align_fault = mem && am && ac && (cpl == USER_CPL) && mode_ok && misaligned;
    end
endmodule

// File: rtl/priv_gate_dbgmap.sv
module priv_gate_dbgmap
    import priv_gate_pkg::*;
#(
    parameter int DBG_IDX_W = 3,
    parameter int ALIAS_LO  = 4,
    parameter int ALIAS_TO  = 6
) (
    input  logic [1:0]           cls,
    input  logic                 de,
    input  logic [DBG_IDX_W-1:0] idx_in,
    output logic [DBG_IDX_W-1:0] idx_out
);
    localparam logic [DBG_IDX_W-1:0] SHIFT = DBG_IDX_W'(ALIAS_TO - ALIAS_LO);
    localparam logic [DBG_IDX_W-1:0] IDX_A = DBG_IDX_W'(ALIAS_LO);
    localparam logic [DBG_IDX_W-1:0] IDX_B = DBG_IDX_W'(ALIAS_LO + 1);

    always_comb begin
        idx_out = idx_in;
        if ((cls_e'(cls) == CLS_DBG) && !de && ((idx_in == IDX_A) || (idx_in == IDX_B)))
            idx_out = idx_in + SHIFT;
    end
endmodule

// File: rtl/priv_gate.sv
module priv_gate
    import priv_gate_pkg::*;
#(
    parameter int CPL_W     = 2,
    parameter int SIZE_W    = 2,
    parameter int ADDR_LO_W = 3,
    parameter int DBG_IDX_W = 3,
    parameter int ALIAS_LO  = 4,
    parameter int ALIAS_TO  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           in_class,
    input  logic [CPL_W-1:0]     in_cpl,
    input  logic [1:0]           in_mode,
    input  logic                 cr0_am,
    input  logic                 cr4_tsd,
    input  logic                 cr4_de,
    input  logic                 cr4_pce,
    input  logic                 eflags_ac,
    input  logic                 in_mem,
    input  logic [SIZE_W-1:0]    in_size,
    input  logic [ADDR_LO_W-1:0] in_addr_lo,
    input  logic [DBG_IDX_W-1:0] in_dbg_idx,
    output logic                 out_valid,
    output logic [1:0]           out_verdict,
    output logic [DBG_IDX_W-1:0] out_dbg_idx
);
    typedef struct packed {
        logic                 vld;
        logic [1:0]           verdict;
        logic [DBG_IDX_W-1:0] idx;
    } gate_state_t;

    gate_state_t st_d, st_q;

    logic                 priv_fault;
    logic [1:0]           priv_code;
    logic                 align_fault;
    logic [DBG_IDX_W-1:0] mapped_idx;

    priv_gate_rules #(
        .CPL_W(CPL_W), .DBG_IDX_W(DBG_IDX_W), .ALIAS_LO(ALIAS_LO)
    ) u_rules (
        .cls(in_class), .cpl(in_cpl), .tsd(cr4_tsd), .pce(cr4_pce), .de(cr4_de),
        .dbg_idx(in_dbg_idx), .fault(priv_fault), .fault_code(priv_code)
    );

    priv_gate_align #(
        .CPL_W(CPL_W), .SIZE_W(SIZE_W), .ADDR_LO_W(ADDR_LO_W)
    ) u_align (
        .mem(in_mem), .am(cr0_am), .ac(eflags_ac), .cpl(in_cpl), .mode(in_mode),
        .size(in_size), .addr_lo(in_addr_lo), .align_fault(align_fault)
    );

    priv_gate_dbgmap #(
        .DBG_IDX_W(DBG_IDX_W), .ALIAS_LO(ALIAS_LO), .ALIAS_TO(ALIAS_TO)
    ) u_dbgmap (
        .cls(in_class), .de(cr4_de), .idx_in(in_dbg_idx), .idx_out(mapped_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.idx = mapped_idx;
            if (priv_fault)
                st_d.verdict = priv_code;
            else if (align_fault)
                st_d.verdict = V_AC;
            else
                st_d.verdict = V_ALLOW;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{vld: 1'b0, verdict: V_ALLOW, idx: '0};
        else
            st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_verdict = st_q.verdict;
    assign out_dbg_idx = st_q.idx;
endmodule

// File: rtl/priv_gate_checker.sv
module priv_gate_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_class,
    input logic [1:0] in_cpl,
    input logic [1:0] in_mode,
    input logic       cr4_tsd,
    input logic       cr4_de,
    input logic       cr4_pce,
    input logic [2:0] in_dbg_idx,
    input logic       out_valid,
    input logic [1:0] out_verdict,
    input logic [2:0] out_dbg_idx
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_tsc_restrict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd1 && cr4_tsd && in_cpl != 2'd0) |=> out_verdict == 2'd1);
    assert_pmc_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd2 && cr4_pce) |=> out_verdict != 2'd1);
    assert_dbg_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd3 && cr4_de && (in_dbg_idx == 3'd4 || in_dbg_idx == 3'd5))
        |=> out_verdict == 2'd2);
    assert_dbg_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd3 && !cr4_de && in_dbg_idx == 3'd4) |=> out_dbg_idx == 3'd6);
    assert_real_no_ac_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mode == 2'd0 || in_mode == 2'd3)) |=> out_verdict != 2'd3);
endmodule

bind priv_gate priv_gate_checker u_priv_gate_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_cpl(in_cpl), .in_mode(in_mode), .cr4_tsd(cr4_tsd), .cr4_de(cr4_de),
    .cr4_pce(cr4_pce), .in_dbg_idx(in_dbg_idx), .out_valid(out_valid),
    .out_verdict(out_verdict), .out_dbg_idx(out_dbg_idx)
);

// File: tb/priv_gate_bench.sv
`timescale 1ns/1ps
module priv_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_class = '0, in_cpl = '0, in_mode = '0, in_size = '0;
    logic       cr0_am = 0, cr4_tsd = 0, cr4_de = 0, cr4_pce = 0, eflags_ac = 0, in_mem = 0;
    logic [2:0] in_addr_lo = '0, in_dbg_idx = '0;
    logic       out_valid;
    logic [1:0] out_verdict;
    logic [2:0] out_dbg_idx;

    int checks = 0;
    int fails  = 0;
    logic [1:0] exp_v = 2'd0;
    logic [2:0] exp_i = 3'd0;
    bit done = 0;

    always #2.5 clk = ~clk;

    priv_gate u_priv_gate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class), .in_cpl(in_cpl),
        .in_mode(in_mode), .cr0_am(cr0_am), .cr4_tsd(cr4_tsd), .cr4_de(cr4_de),
        .cr4_pce(cr4_pce), .eflags_ac(eflags_ac), .in_mem(in_mem), .in_size(in_size),
        .in_addr_lo(in_addr_lo), .in_dbg_idx(in_dbg_idx), .out_valid(out_valid),
        .out_verdict(out_verdict), .out_dbg_idx(out_dbg_idx)
    );

    function automatic logic [1:0] model_verdict();
        logic [2:0] mask;
        logic ac_hit;
        mask   = (in_size == 2'd0) ? 3'b000 : (in_size == 2'd1) ? 3'b001 :
                 (in_size == 2'd2) ? 3'b011 : 3'b111;
        ac_hit = in_mem && cr0_am && eflags_ac && in_cpl == 2'd3 &&
                 (in_mode == 2'd1 || in_mode == 2'd2) && ((in_addr_lo & mask) != 0);
        if (in_class == 2'd1 && cr4_tsd && in_cpl != 0) return 2'd1;
        if (in_class == 2'd2 && !cr4_pce && in_cpl != 0) return 2'd1;
        if (in_class == 2'd3 && cr4_de && (in_dbg_idx == 4 || in_dbg_idx == 5)) return 2'd2;
        if (ac_hit) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [2:0] model_idx();
        if (in_class == 2'd3 && !cr4_de && (in_dbg_idx == 4 || in_dbg_idx == 5))
            return in_dbg_idx + 3'd2;
        return in_dbg_idx;
    endfunction

    function automatic string tag_of();
        if (in_class == 2'd1) return "R3";
        if (in_class == 2'd2) return "R4";
        if (in_class == 2'd3 && cr4_de) return "R5";
        if (in_class == 2'd3) return "R6";
        if (in_mode == 2'd0 || in_mode == 2'd3) return "R9";
        return "R7";
    endfunction

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // inputs are already set; one clock, then compare at the falling edge
    task automatic step(input string tag);
        if (in_valid) begin
            exp_v = model_verdict();
            exp_i = model_idx();
        end
        @(negedge clk);
        check(out_valid == in_valid, "R2", "out_valid", out_valid, in_valid);
        check(out_verdict == exp_v, tag, "verdict", out_verdict, exp_v);
        check(out_dbg_idx == exp_i, tag, "dbg_idx", out_dbg_idx, exp_i);
    endtask

    task automatic setv(input logic [1:0] c, input logic [1:0] p, input logic [1:0] m,
                        input logic mem, input logic [1:0] sz, input logic [2:0] a,
                        input logic [2:0] d);
        in_valid = 1; in_class = c; in_cpl = p; in_mode = m;
        in_mem = mem; in_size = sz; in_addr_lo = a; in_dbg_idx = d;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_verdict == 0 && out_dbg_idx == 0, "R1",
              "reset state", {out_valid, out_verdict, out_dbg_idx}, 0);
        rst_n = 1;
        @(negedge clk);
        check(out_valid == 0 && out_verdict == 0, "R1", "idle after reset",
              {out_valid, out_verdict}, 0);

        // R3 time-stamp boundaries
        cr4_tsd = 1; setv(2'd1, 2'd0, 2'd1, 0, 0, 0, 0); step("R3");
        setv(2'd1, 2'd3, 2'd1, 0, 0, 0, 0); step("R3");
        cr4_tsd = 0; setv(2'd1, 2'd3, 2'd1, 0, 0, 0, 0); step("R3");
        // R4 counter boundaries
        cr4_pce = 0; setv(2'd2, 2'd3, 2'd1, 0, 0, 0, 0); step("R4");
        setv(2'd2, 2'd0, 2'd1, 0, 0, 0, 0); step("R4");
        cr4_pce = 1; setv(2'd2, 2'd3, 2'd2, 0, 0, 0, 0); step("R4");
        // R5 / R6 debug indices
        for (int de = 0; de < 2; de++)
            for (int d = 3; d < 7; d++) begin
                cr4_de = de[0];
                setv(2'd3, 2'd0, 2'd1, 0, 0, 0, 3'(d));
                step(de ? "R5" : "R6");
            end
        // R8 every size and address, all enables set
        cr0_am = 1; eflags_ac = 1;
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 8; a++) begin
                setv(2'd0, 2'd3, 2'd1, 1, 2'(s), 3'(a), 0);
                step("R8");
            end
        // R7 drop one enable at a time
        setv(2'd0, 2'd2, 2'd1, 1, 2'd2, 3'd2, 0); step("R7");
        setv(2'd0, 2'd3, 2'd2, 1, 2'd2, 3'd2, 0); step("R7");
        cr0_am = 0; setv(2'd0, 2'd3, 2'd1, 1, 2'd2, 3'd2, 0); step("R7");
        cr0_am = 1; eflags_ac = 0; step("R7");
        eflags_ac = 1; in_mem = 0; step("R7");
        // R9 real and code-3 modes
        setv(2'd0, 2'd3, 2'd0, 1, 2'd3, 3'd1, 0); step("R9");
        setv(2'd0, 2'd3, 2'd3, 1, 2'd3, 3'd1, 0); step("R9");
        // R10 privilege fault beats alignment fault
        cr4_tsd = 1; setv(2'd1, 2'd3, 2'd1, 1, 2'd3, 3'd4, 0); step("R10");
        cr4_pce = 0; setv(2'd2, 2'd3, 2'd2, 1, 2'd1, 3'd1, 0); step("R10");
        cr4_de = 1; setv(2'd3, 2'd3, 2'd1, 1, 2'd2, 3'd1, 3'd5); step("R10");
        // R2 idle cycle holds verdict and drops valid
        in_valid = 0; step("R2");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            in_valid   = ($urandom % 4) != 0;
            in_class   = 2'($urandom);
            in_cpl     = ($urandom % 2) ? 2'd3 : 2'($urandom);
            in_mode    = 2'($urandom);
            cr0_am     = ($urandom % 4) != 0;
            eflags_ac  = ($urandom % 4) != 0;
            cr4_tsd    = 1'($urandom);
            cr4_de     = 1'($urandom);
            cr4_pce    = 1'($urandom);
            in_mem     = 1'($urandom);
            in_size    = 2'($urandom);
            in_addr_lo = 3'($urandom);
            in_dbg_idx = ($urandom % 2) ? 3'(4 + $urandom % 2) : 3'($urandom);
            step(tag_of());
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule